// File: doc/BRIEF.md
# Power-of-Two Serial Clock Prescaler

This block derives the clock for a serial port by dividing a selectable source by a power of two from 1 to 256. Software programs the ratio through a 32-bit control word. The low eight bits hold the divisor as a one-hot code, and the remaining bits are fixed at zero. A code of all zeros passes the source through undivided, and that is also the state after reset.

The whole block runs on the bus clock. The two candidate sources are modelled as clock enables. When the bus clock is chosen, every bus cycle counts as a source cycle. When the oscillator is chosen, a cycle counts as a source cycle only while the oscillator enable input is high.

The divider emits a one-cycle pulse at the divided rate and a square-wave output for the serial port. A new ratio or a new source is applied only where the current output period ends, so that period always runs to its full length.

Top module: `sclk_prescaler`

## Requirements
- R1: After reset the control word reads 0, the error flag is low, and the pulse output is high once for every source cycle.
- R2: Bits 7:0 of a written word are stored and read back. Bits 31:8 always read 0, and anything written to them has no effect.
- R3: With a divisor code of 0x00, the output period is one source cycle.
- R4: With only bit k of the divisor code set (k = 0..7), the pulse output repeats every 2^(k+1) source cycles.
- R5: For ratios of 2 or more, the square-wave output rises in the cycle of each pulse and stays high for exactly half the period. At ratio 1 it is high exactly in the pulse cycles.
- R6: A write whose low eight bits have two or more bits set is discarded. The read value and the running ratio stay unchanged.
- R7: Such a discarded write sets a sticky error flag. Only reset clears the flag.
- R8: A ratio written mid-period takes effect only after the current period completes at its old length.
- R9: The source select chooses the bus clock (1) or the oscillator enable (0). A change of select is applied at a period boundary, and counting restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state is clocked here |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 1 | Source choice: 1 selects the bus clock, 0 selects the oscillator enable |
| osc_tick | input | 1 | Oscillator-derived source enable, one bus cycle wide per source cycle |
| wr_en | input | 1 | Writes wr_data into the control word |
| wr_data | input | 32 | Write value; bits 7:0 hold the one-hot divisor code |
| rd_data | output | 32 | Current control word |
| wr_err | output | 1 | Sticky flag set by a rejected multi-bit divisor write |
| div_pulse | output | 1 | One-cycle enable at the divided rate |
| div_clk | output | 1 | Divided square-wave clock for the serial port |

## Verification
The bench measures the pulse period and the high time of the square wave for every legal code. A decode that is off by one would give periods of half or double the expected length. To test runt protection, it writes a short ratio ten cycles into a 256-cycle period and checks that the period still lasts 256 cycles. A design that reloads immediately would cut that period short. A multi-bit code and a word with reserved bits set are both written. A design that stores the illegal code or lets the upper bits leak would show a changed ratio or a non-zero read. The bench then switches to the oscillator enable and back, and expects the period to scale by the enable spacing.

// File: rtl/presc_pkg.sv
package presc_pkg;

  typedef enum logic {
    SRC_OSC = 1'b0,
    SRC_BUS = 1'b1
  } src_e;

endpackage

// File: rtl/presc_cfg.sv
module presc_cfg #(
  parameter int REG_W = 32,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic [DIV_W-1:0] field_o,
  output logic             err_o
);

  localparam int PAD_W = REG_W - DIV_W;

  logic [DIV_W-1:0] field_q;
  logic [DIV_W-1:0] new_field;
  logic             multi_hot;
  logic             err_q;

  assign new_field = wr_data[DIV_W-1:0];
  assign multi_hot = ($countones(new_field) > 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      field_q <= '0;
      err_q   <= 1'b0;
    end else if (wr_en) begin
      if (multi_hot) err_q   <= 1'b1;
      else           field_q <= new_field;
    end
  end

  assign rd_data = {{PAD_W{1'b0}}, field_q};
  assign field_o = field_q;
  assign err_o   = err_q;

  // R6: an illegal code leaves the stored field untouched
  a_r6_bad_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && multi_hot) |=> (field_q == $past(field_q)));

  // R7: the flag never drops while out of reset
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R7: the flag only rises after a write
  a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(wr_en));

endmodule

// File: rtl/presc_src.sv
module presc_src
  import presc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic osc_tick_i,
  input  logic load_i,
  output logic tick_o
);

  src_e sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= SRC_BUS;
    else if (load_i) sel_q <= src_e'(sel_i);
  end

  assign tick_o = (sel_q == SRC_BUS) ? 1'b1 : osc_tick_i;

  // R9: the active source only changes at a period boundary
  a_r9_sel_at_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> $past(load_i));

endmodule

// File: rtl/presc_core.sv
module presc_core #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] field_i,
  output logic             bound_o,
  output logic             pulse_o,
  output logic             dclk_o
);

  localparam int CNT_W = DIV_W;
  localparam int SH_W  = $clog2(DIV_W + 1);

  logic [SH_W-1:0]  sh_q;
  logic [SH_W-1:0]  sh_next;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;
  logic [CNT_W-1:0] half_m1;
  logic             bound;
  logic             pulse_q;
  logic             dclk_q;

  // one-hot code to shift amount: bit k gives k+1, zero gives 0
  always_comb begin
    sh_next = '0;
    for (int i = 0; i < DIV_W; i++) begin
      if (field_i[i]) sh_next = SH_W'(i + 1);
    end
  end

  // last count of the period: 2^sh - 1 as a low-bit mask
  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      term[i] = (i < int'(sh_q));
    end
  end

  assign half_m1 = term >> 1;
  assign bound   = tick_i && (cnt_q == term);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= bound;
      if (bound) begin
        cnt_q <= '0;
        sh_q  <= sh_next;
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                               dclk_q <= 1'b0;
    else if (sh_q == '0)                      dclk_q <= tick_i;
    else if (bound)                           dclk_q <= 1'b1;
    else if (tick_i && (cnt_q == half_m1))    dclk_q <= 1'b0;
  end

  assign bound_o = bound;
  assign pulse_o = pulse_q;
  assign dclk_o  = dclk_q;

  // R8: the ratio only changes at a completed period
  a_r8_ratio_at_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sh_q) |-> $past(bound));

  // R4: the count never passes the end of the period
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= term);

  // R1: each pulse follows a source cycle
  a_r1_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> $past(tick_i));

  // R5: for ratios of two or more the square wave moves only on source cycles
  a_r5_dclk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_q != '0 && !tick_i) |=> $stable(dclk_q));

endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler #(
  parameter int REG_W = 32,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_sel,
  input  logic             osc_tick,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             wr_err,
  output logic             div_pulse,
  output logic             div_clk
);

  logic [DIV_W-1:0] field;
  logic             tick;
  logic             bound;

  presc_cfg #(.REG_W(REG_W), .DIV_W(DIV_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .field_o (field),
    .err_o   (wr_err)
  );

  presc_src u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (src_sel),
    .osc_tick_i (osc_tick),
    .load_i     (bound),
    .tick_o     (tick)
  );

  presc_core #(.DIV_W(DIV_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .field_i (field),
    .bound_o (bound),
    .pulse_o (div_pulse),
    .dclk_o  (div_clk)
  );

endmodule

// File: tb/sclk_prescaler_test.sv
module sclk_prescaler_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  localparam int WDOG = 150000;

  localparam logic [31:0] V_WR  [NV] = '{32'h01, 32'h02, 32'h04, 32'h08, 32'h10, 32'h20,
                                         32'h40, 32'h80, 32'h00, 32'hFFFF_FF10, 32'h05};
  localparam logic [31:0] V_RD  [NV] = '{32'h01, 32'h02, 32'h04, 32'h08, 32'h10, 32'h20,
                                         32'h40, 32'h80, 32'h00, 32'h10, 32'h10};
  localparam int          V_N   [NV] = '{2, 4, 8, 16, 32, 64, 128, 256, 1, 32, 32};
  localparam logic        V_ERR [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_sel = 1'b1;
  logic        osc_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        wr_err;
  logic        div_pulse;
  logic        div_clk;

  int checks = 0;
  int errors = 0;
  int osc_cnt = 0;

  sclk_prescaler uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_sel   (src_sel),
    .osc_tick  (osc_tick),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .wr_err    (wr_err),
    .div_pulse (div_pulse),
    .div_clk   (div_clk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // oscillator enable: one cycle in three
  always @(negedge clk) begin
    osc_cnt  = (osc_cnt == 2) ? 0 : osc_cnt + 1;
    osc_tick = (osc_cnt == 2);
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // cycles from one pulse to the next, and div_clk high cycles in between
  task automatic measure(output int per, output int hi);
    per = 0;
    hi  = 0;
    do @(negedge clk); while (!div_pulse);
    do begin
      @(negedge clk);
      per++;
      if (div_clk) hi++;
    end while (!div_pulse);
  endtask

  initial begin
    int per, hi, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(rd_data == 32'h0, "R1 readback", rd_data, 0);
    check(wr_err == 1'b0, "R1 error flag", wr_err, 0);
    measure(per, hi);
    check(per == 1, "R1 period", per, 1);
    check(hi == 1, "R5 ratio-1 high", hi, 1);

    // R2 R3 R4 R5 R6 R7: vector walk on the bus clock
    for (int i = 0; i < NV; i++) begin
      wr(V_WR[i]);
      check(rd_data == V_RD[i], "R2/R6 readback", rd_data, V_RD[i]);
      check(wr_err == V_ERR[i], "R7 error flag", wr_err, V_ERR[i]);
      measure(per, hi);
      measure(per, hi);
      check(per == V_N[i], "R3/R4/R6 period", per, V_N[i]);
      check(hi == ((V_N[i] == 1) ? 1 : V_N[i] / 2), "R5 high time", hi,
            (V_N[i] == 1) ? 1 : V_N[i] / 2);
    end

    // R8: a short ratio written mid-period does not cut the period
    wr(32'h80);
    measure(per, hi);
    measure(per, hi);
    do @(negedge clk); while (!div_pulse);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 10) begin
        wr_en   = 1'b1;
        wr_data = 32'h02;
      end else begin
        wr_en = 1'b0;
      end
    end while (!div_pulse);
    wr_en = 1'b0;
    check(n == 256, "R8 old period completes", n, 256);
    measure(per, hi);
    check(per == 4, "R8 new period", per, 4);

    // R9: oscillator source, then back to the bus clock
    src_sel = 1'b0;
    measure(per, hi);
    measure(per, hi);
    measure(per, hi);
    check(per == 12, "R9 oscillator period", per, 12);
    src_sel = 1'b1;
    measure(per, hi);
    measure(per, hi);
    check(per == 4, "R9 bus period", per, 4);

    // R7: flag still set, cleared only by reset
    check(wr_err == 1'b1, "R7 flag held", wr_err, 1);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(wr_err == 1'b0, "R7 cleared by reset", wr_err, 0);
    check(rd_data == 32'h0, "R1 readback after reset", rd_data, 0);
    measure(per, hi);
    check(per == 1, "R1 period after reset", per, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", WDOG, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule